// File: doc/BRIEF.md
# Offset and Clock-Select Configuration Register Bank

This block keeps the ten 8-bit setup registers of a buffer controller: two 10-bit threshold offsets (one for the near-empty warning, one for the near-full warning) and a bit that says which of the two port clocks is the faster one. Software can fill the bank in two ways. The parallel path has no address: each enabled write-clock edge stores the low byte of the data bus into the next register, and a pointer steps through the registers in a fixed order and wraps. The serial path uses its own clock and a data line. It carries framed writes, and each frame addresses one register.

Readback uses the parallel path only. A second pointer, clocked by the read clock, steps through the same order. New register contents do not reach the offset and clock-select outputs at once. They pass through only after a fixed settling window of write-clock cycles. Master reset restores every default. Partial reset keeps the register contents and restarts the sequencing.

Top module: `cfgRegFile`

## Requirements
- R1: While `mrstN` is low, and after it rises, the bank holds its defaults. Registers 1, 2, 3, 5, 6, 8 and 9 hold 0x00, registers 4 and 7 hold 0x7F, and register 10 holds 0x80. After master reset `ofsN` = 0x07F, `ofsM` = 0x07F, `fastClk` = 1 and `rdata` = 0x00.
- R2: A parallel write takes place on a `wclk` rising edge when `serEnN`=1, `ldN`=0 and `wenN`=0. It stores `din` into the register the write pointer selects. The write pointer starts at register 1, moves up by one on each write, and returns to register 1 after register 10.
- R3: A parallel read takes place on an `rclk` rising edge when `serEnN`=1, `ldN`=0, `renN`=0 and `wenN`=1. It loads `rdata` with the register the read pointer selects. The read pointer follows the same order 1..10 and wraps, and it is independent of the write pointer. At all other times `rdata` holds its value.
- R4: If `ldN`, `wenN` and `renN` are all low (with `serEnN`=1) on the same edge, the write takes place, the read pointer does not move, and `rdata` keeps its value.
- R5: `ofsN` = {register 5 bits [1:0], register 4}. `ofsM` = {register 8 bits [1:0], register 7}. `fastClk` = register 10 bit 7.
- R6: A register write reaches `ofsN`/`ofsM`/`fastClk` on the 8th `wclk` rising edge after the edge of the write. Any write inside that window starts the count again from the later write.
- R7: While `serEnN`=0, each `sclk` rising edge shifts in `sdi`. A frame is 12 bits: a 4-bit register address MSB first, then 8 data bits MSB first. After the 12th bit the addressed register is written in the `wclk` domain, within a few `wclk` cycles.
- R8: Raising `serEnN` before the 12th bit throws away the partial frame. The next frame starts from its first bit.
- R9: A serial frame whose address is 0 or 11..15 changes no register.
- R10: A low pulse on `prstN` returns both parallel pointers and the serial bit count to their start and clears `rdata`. All register contents and the offset outputs keep their values.
- R11: With `ldN`=1, or with `serEnN`=0, the parallel `wenN`/`renN` strobes do nothing. Neither pointer moves, no register changes, and `rdata` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock (parallel writes, settling, outputs) |
| rclk | input | 1 | Read clock (parallel readback) |
| sclk | input | 1 | Serial shift clock |
| mrstN | input | 1 | Master reset, active low, asynchronous |
| prstN | input | 1 | Partial reset, active low, asynchronous |
| serEnN | input | 1 | Low selects serial loading, high selects the parallel path |
| ldN | input | 1 | Low routes the parallel strobes to this register bank |
| wenN | input | 1 | Parallel write strobe, active low |
| renN | input | 1 | Parallel read strobe, active low |
| din | input | 8 | Parallel write data |
| sdi | input | 1 | Serial data |
| rdata | output | 8 | Parallel readback data |
| ofsN | output | 10 | Committed near-empty offset |
| ofsM | output | 10 | Committed near-full offset |
| fastClk | output | 1 | Committed clock-select bit |

## Verification
The bench writes twelve values in a row, so the write pointer has to wrap. It then reads the whole bank from wherever the read pointer happens to be. An off-by-one wrap, or a read pointer shared with the write side, would show up as a byte in the wrong place. It samples the offsets on the 7th and 8th edges after a write, and again after a second write in the middle of the window. A design that commits early, late, or without restarting the count fails there. Serial tests send an aborted fragment just before a valid frame, and frames with illegal addresses. A design that keeps stale bits or decodes address 0 or 11..15 would corrupt a register. Collision, ignored-strobe and partial-reset tests check that the pointers sit where the requirements say and that the registers survive.

// File: rtl/cfgRegPkg.sv
package cfgRegPkg;
  localparam int NUM_REGS   = 10;
  localparam int REG_W      = 8;
  localparam int ADDR_W     = 4;
  localparam int IDX_W      = 4;
  localparam int OFS_W      = 10;
  localparam int FRAME_BITS = ADDR_W + REG_W;
  localparam int CNT_W      = $clog2(FRAME_BITS);

  // register indices (address minus one) decoded by the offset outputs
  localparam int IDX_N_LO = 3;
  localparam int IDX_N_HI = 4;
  localparam int IDX_M_LO = 6;
  localparam int IDX_M_HI = 7;
  localparam int IDX_CLK  = 9;

  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic [REG_W-1:0] wrData;
    logic             rdEn;
    logic [IDX_W-1:0] rdIdx;
  } cfgStrobe_t;

  function automatic logic [REG_W-1:0] regDefault(input int idx);
    if (idx == IDX_N_LO || idx == IDX_M_LO) return 8'h7F;
    if (idx == IDX_CLK) return 8'h80;
    return '0;
  endfunction

  function automatic logic [IDX_W-1:0] nextIdx(input logic [IDX_W-1:0] idx);
    return (idx == IDX_W'(NUM_REGS - 1)) ? '0 : idx + 1'b1;
  endfunction
endpackage

// File: rtl/cfgSeqCtrl.sv
module cfgSeqCtrl
  import cfgRegPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             sclk,
  input  logic             mrstN,
  input  logic             prstN,
  input  logic             serEnN,
  input  logic             ldN,
  input  logic             wenN,
  input  logic             renN,
  input  logic [REG_W-1:0] din,
  input  logic             sdi,
  output cfgStrobe_t       strb
);
  logic ptrRstN;
  assign ptrRstN = mrstN & prstN;

  logic             parWr, parRd;
  logic [IDX_W-1:0] wrPtr, rdPtr;

  assign parWr = serEnN & ~ldN & ~wenN;
  assign parRd = serEnN & ~ldN & ~renN & wenN; // write wins on a collision

  // ---------------- serial shifter (sclk domain) ----------------
  logic [FRAME_BITS-2:0] shiftQ;
  logic [CNT_W-1:0]      bitCnt;
  logic [ADDR_W-1:0]     frameAddr;
  logic [REG_W-1:0]      frameData;
  logic                  frameTgl;

  always_ff @(posedge sclk or negedge ptrRstN) begin
    if (!ptrRstN) begin
      shiftQ <= '0;
      bitCnt <= '0;
    end else if (serEnN) begin
      bitCnt <= '0;
    end else if (bitCnt == CNT_W'(FRAME_BITS - 1)) begin
      bitCnt <= '0;
    end else begin
      shiftQ <= {shiftQ[FRAME_BITS-3:0], sdi};
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge sclk or negedge mrstN) begin
    if (!mrstN) begin
      frameAddr <= '0;
      frameData <= '0;
      frameTgl  <= 1'b0;
    end else if (!serEnN && bitCnt == CNT_W'(FRAME_BITS - 1)) begin
      frameAddr <= shiftQ[FRAME_BITS-2 -: ADDR_W];
      frameData <= {shiftQ[REG_W-2:0], sdi};
      frameTgl  <= ~frameTgl;
    end
  end

  // ---------------- frame handoff into wclk domain ----------------
  logic [SYNC_STAGES:0] syncQ;
  logic                 serPulse, addrOk;

  always_ff @(posedge wclk or negedge mrstN) begin
    if (!mrstN) syncQ <= '0;
    else        syncQ <= {syncQ[SYNC_STAGES-1:0], frameTgl};
  end

  assign serPulse = syncQ[SYNC_STAGES] ^ syncQ[SYNC_STAGES-1];
  assign addrOk   = (frameAddr != '0) && (frameAddr <= ADDR_W'(NUM_REGS));

  // ---------------- parallel sequence pointers ----------------
  always_ff @(posedge wclk or negedge ptrRstN) begin
    if (!ptrRstN)   wrPtr <= '0;
    else if (parWr) wrPtr <= nextIdx(wrPtr);
  end

  always_ff @(posedge rclk or negedge ptrRstN) begin
    if (!ptrRstN)   rdPtr <= '0;
    else if (parRd) rdPtr <= nextIdx(rdPtr);
  end

  // parallel write takes precedence over a serial commit in the same cycle
  always_comb begin
    strb.wrEn   = parWr | (serPulse & addrOk);
    strb.wrIdx  = parWr ? wrPtr : IDX_W'(frameAddr - 1'b1);
    strb.wrData = parWr ? din : frameData;
    strb.rdEn   = parRd;
    strb.rdIdx  = rdPtr;
  end

  // ---------------- assertions ----------------
  assert_wr_range_R2: assert property (@(posedge wclk) disable iff (!ptrRstN)
    wrPtr < IDX_W'(NUM_REGS));

  assert_rd_range_R3: assert property (@(posedge rclk) disable iff (!ptrRstN)
    rdPtr < IDX_W'(NUM_REGS));

  assert_collide_hold_R4: assert property (@(posedge rclk) disable iff (!ptrRstN)
    (serEnN && !ldN && !wenN && !renN) |=> $stable(rdPtr));

  assert_ld_hold_R11: assert property (@(posedge wclk) disable iff (!ptrRstN)
    (ldN || !serEnN) |=> $stable(wrPtr));

  assert_abort_R8: assert property (@(posedge sclk) disable iff (!ptrRstN)
    serEnN |=> (bitCnt == '0));
endmodule

// File: rtl/cfgRegBank.sv
module cfgRegBank
  import cfgRegPkg::*;
#(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             mrstN,
  input  logic             prstN,
  input  cfgStrobe_t       strb,
  output logic [REG_W-1:0] rdata,
  output logic [OFS_W-1:0] ofsN,
  output logic [OFS_W-1:0] ofsM,
  output logic             fastClk
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);

  logic [REG_W-1:0] bank [NUM_REGS];
  logic [OFS_W-1:0] liveN, liveM;
  logic             liveClk;
  logic [CW-1:0]    settleCnt;
  logic             pending, commitNow;

  always_ff @(posedge wclk or negedge mrstN) begin
    if (!mrstN) begin
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= regDefault(i);
    end else if (strb.wrEn) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (strb.wrIdx == IDX_W'(i)) bank[i] <= strb.wrData;
    end
  end

  assign liveN   = {bank[IDX_N_HI][OFS_W-REG_W-1:0], bank[IDX_N_LO]};
  assign liveM   = {bank[IDX_M_HI][OFS_W-REG_W-1:0], bank[IDX_M_LO]};
  assign liveClk = bank[IDX_CLK][REG_W-1];

  assign commitNow = pending && (settleCnt == '0);

  // settling window: restarted by every write, outputs follow at its end
  always_ff @(posedge wclk or negedge mrstN) begin
    if (!mrstN) begin
      pending   <= 1'b0;
      settleCnt <= '0;
      ofsN      <= {regDefault(IDX_N_HI)[OFS_W-REG_W-1:0], regDefault(IDX_N_LO)};
      ofsM      <= {regDefault(IDX_M_HI)[OFS_W-REG_W-1:0], regDefault(IDX_M_LO)};
      fastClk   <= regDefault(IDX_CLK)[REG_W-1];
    end else if (strb.wrEn) begin
      pending   <= 1'b1;
      settleCnt <= CW'(SETTLE_CYCLES - 1);
    end else if (commitNow) begin
      pending <= 1'b0;
      ofsN    <= liveN;
      ofsM    <= liveM;
      fastClk <= liveClk;
    end else if (pending) begin
      settleCnt <= settleCnt - 1'b1;
    end
  end

  always_ff @(posedge rclk or negedge mrstN or negedge prstN) begin
    if (!mrstN || !prstN) rdata <= '0;
    else if (strb.rdEn)   rdata <= bank[strb.rdIdx];
  end

  assert_eff_hold_R6: assert property (@(posedge wclk) disable iff (!mrstN)
    !commitNow |=> ($stable(ofsN) && $stable(ofsM) && $stable(fastClk)));

  assert_restart_R6: assert property (@(posedge wclk) disable iff (!mrstN)
    strb.wrEn |=> (pending && settleCnt == CW'(SETTLE_CYCLES - 1)));

  assert_rd_hold_R3: assert property (@(posedge rclk) disable iff (!mrstN || !prstN)
    !strb.rdEn |=> $stable(rdata));
endmodule

// File: rtl/cfgRegFile.sv
module cfgRegFile
  import cfgRegPkg::*;
#(
  parameter int SETTLE_CYCLES = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic        wclk,
  input  logic        rclk,
  input  logic        sclk,
  input  logic        mrstN,
  input  logic        prstN,
  input  logic        serEnN,
  input  logic        ldN,
  input  logic        wenN,
  input  logic        renN,
  input  logic [7:0]  din,
  input  logic        sdi,
  output logic [7:0]  rdata,
  output logic [9:0]  ofsN,
  output logic [9:0]  ofsM,
  output logic        fastClk
);
  cfgStrobe_t strb;

  cfgSeqCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .wclk(wclk), .rclk(rclk), .sclk(sclk), .mrstN(mrstN), .prstN(prstN),
    .serEnN(serEnN), .ldN(ldN), .wenN(wenN), .renN(renN), .din(din),
    .sdi(sdi), .strb(strb)
  );

  cfgRegBank #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_bank (
    .wclk(wclk), .rclk(rclk), .mrstN(mrstN), .prstN(prstN), .strb(strb),
    .rdata(rdata), .ofsN(ofsN), .ofsM(ofsM), .fastClk(fastClk)
  );
endmodule

// File: tb/cfgRegFile_bench.sv
`timescale 1ns/1ps
module cfgRegFile_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic mrstN = 1'b0, prstN = 1'b1, serEnN = 1'b1, ldN = 1'b1;
  logic wenN = 1'b1, renN = 1'b1, sdi = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] rdata;
  logic [9:0] ofsN, ofsM;
  logic fastClk;

  cfgRegFile u_cfgRegFile (
    .wclk(clk), .rclk(clk), .sclk(clk), .mrstN(mrstN), .prstN(prstN),
    .serEnN(serEnN), .ldN(ldN), .wenN(wenN), .renN(renN), .din(din),
    .sdi(sdi), .rdata(rdata), .ofsN(ofsN), .ofsM(ofsM), .fastClk(fastClk)
  );

  int checks = 0, errors = 0;
  logic [7:0] expReg [10];
  int expWr = 0, expRd = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic loadDefaults();
    for (int i = 0; i < 10; i++) expReg[i] = 8'h00;
    expReg[3] = 8'h7F; expReg[6] = 8'h7F; expReg[9] = 8'h80;
    expWr = 0; expRd = 0;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic parWrite(input logic [7:0] d);
    serEnN = 1; ldN = 0; wenN = 0; din = d;
    @(negedge clk);
    ldN = 1; wenN = 1;
    expReg[expWr] = d;
    expWr = (expWr + 1) % 10;
  endtask

  task automatic readAll(input string req);
    serEnN = 1; ldN = 0; renN = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(req, rdata, expReg[expRd]);
      expRd = (expRd + 1) % 10;
    end
    ldN = 1; renN = 1;
  endtask

  function automatic logic [9:0] modelN();
    return {expReg[4][1:0], expReg[3]};
  endfunction
  function automatic logic [9:0] modelM();
    return {expReg[7][1:0], expReg[6]};
  endfunction

  task automatic sendBits(input logic [11:0] bits, input int n);
    for (int i = 0; i < n; i++) begin
      serEnN = 0; sdi = bits[11 - i];
      @(negedge clk);
    end
    serEnN = 1; sdi = 0;
  endtask

  task automatic sendFrame(input logic [3:0] a, input logic [7:0] d);
    sendBits({a, d}, 12);
    if (a >= 1 && a <= 10) expReg[a - 1] = d;
    waitEdges(14);
  endtask

  task automatic t_reset();
    chk("R1 ofsN", ofsN, 10'h07F);
    chk("R1 ofsM", ofsM, 10'h07F);
    chk("R1 fastClk", fastClk, 1);
    chk("R1 rdata", rdata, 0);
    readAll("R1 defaults readback");
  endtask

  task automatic t_parallel();
    for (int i = 0; i < 12; i++) parWrite(8'hA0 + 8'(i)); // wraps past register 10 (R2)
    readAll("R2/R3 sequence after wrap");
    waitEdges(10);
    chk("R5 ofsN", ofsN, modelN());
    chk("R5 ofsM", ofsM, modelM());
    chk("R5 fastClk", fastClk, expReg[9][7]);
  endtask

  task automatic t_settle();
    logic [9:0] oldN;
    oldN = ofsN;
    while (expWr != 3) parWrite(8'h00 + 8'(expWr));
    parWrite(8'h55);                 // register 4
    waitEdges(7);
    chk("R6 before 8th edge", ofsN, oldN);
    waitEdges(1);
    chk("R6 on 8th edge", ofsN, modelN());
    oldN = ofsN;
    parWrite(8'h02);                 // register 5
    waitEdges(3);
    parWrite(8'h11);                 // register 6, restarts window
    waitEdges(7);
    chk("R6 restart holds", ofsN, oldN);
    waitEdges(1);
    chk("R6 restart commit", ofsN, modelN());
  endtask

  task automatic t_collide();
    logic [7:0] held;
    serEnN = 1; ldN = 0; renN = 0;
    @(negedge clk);
    ldN = 1; renN = 1;
    chk("R3 single read", rdata, expReg[expRd]);
    expRd = (expRd + 1) % 10;
    held = rdata;
    ldN = 0; renN = 0; wenN = 0; din = 8'h3C;
    @(negedge clk);
    ldN = 1; renN = 1; wenN = 1;
    expReg[expWr] = 8'h3C; expWr = (expWr + 1) % 10;
    chk("R4 rdata held", rdata, held);
    readAll("R4 pointers after collision");
  endtask

  task automatic t_ignored();
    logic [7:0] held;
    held = rdata;
    ldN = 1; wenN = 0; renN = 0; din = 8'hEE;
    @(negedge clk);
    wenN = 1; renN = 1;
    chk("R11 ldN high rdata", rdata, held);
    serEnN = 0; sdi = 0; ldN = 0; wenN = 0;
    @(negedge clk);
    serEnN = 1; ldN = 1; wenN = 1;
    waitEdges(2);
    readAll("R11 no change");
    parWrite(8'h77);
    readAll("R11 write pointer unmoved");
  endtask

  task automatic t_serial();
    sendFrame(4'd8, 8'h01);
    waitEdges(10);
    chk("R7 ofsM", ofsM, modelM());
    sendFrame(4'd10, 8'h00);
    waitEdges(10);
    chk("R7 fastClk", fastClk, 0);
    readAll("R7 serial readback");
  endtask

  task automatic t_abort();
    sendBits(12'b1001_1100_0000, 6);  // partial frame, then serEnN high
    @(negedge clk);
    sendFrame(4'd1, 8'h5A);
    readAll("R8 aborted frame discarded");
  endtask

  task automatic t_badAddr();
    logic [9:0] n0, m0;
    n0 = ofsN; m0 = ofsM;
    sendFrame(4'd0, 8'hFF);
    sendFrame(4'd11, 8'hFF);
    sendFrame(4'd15, 8'hFF);
    waitEdges(10);
    chk("R9 ofsN unchanged", ofsN, n0);
    chk("R9 ofsM unchanged", ofsM, m0);
    readAll("R9 bank unchanged");
  endtask

  task automatic t_prst();
    logic [9:0] n0, m0;
    parWrite(8'h21); parWrite(8'h22);
    waitEdges(10);
    n0 = ofsN; m0 = ofsM;
    serEnN = 0; sdi = 1;             // stray serial bits before reset
    waitEdges(3);
    prstN = 0; serEnN = 1; sdi = 0;
    @(negedge clk);
    prstN = 1;
    expWr = 0; expRd = 0;
    chk("R10 rdata cleared", rdata, 0);
    chk("R10 ofsN kept", ofsN, n0);
    chk("R10 ofsM kept", ofsM, m0);
    readAll("R10 contents kept");
    parWrite(8'h9D);
    readAll("R10 write pointer at 1");
    sendFrame(4'd2, 8'h66);
    readAll("R10 serial count restarted");
  endtask

  task automatic t_mrst();
    mrstN = 0;
    @(negedge clk);
    chk("R1 in reset ofsM", ofsM, 10'h07F);
    mrstN = 1;
    loadDefaults();
    chk("R1 again fastClk", fastClk, 1);
    readAll("R1 again defaults");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    loadDefaults();
    waitEdges(3);
    mrstN = 1;
    @(negedge clk);
    t_reset();
    t_parallel();
    t_settle();
    t_collide();
    t_ignored();
    t_serial();
    t_abort();
    t_badAddr();
    t_prst();
    t_mrst();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule